// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block is a free-running cycle counter paired with a compare register. The top bit of each register's write data is not part of the value. It is a shared disable flag. The counter advances by one on every cycle in which `tick_en` is high. When the count reaches the programmed compare value, the block emits a one-cycle pulse that sets a soft-interrupt bit and wakes the core.

Software reaches both registers through a single-cycle write port and a combinational read port. `wr_sel` and `rd_sel` choose between the count and the compare value. A read returns the stored value in the low bits and the disable flag in the top bit.

A parameter selects which soft-interrupt bit the pulse drives. The ordinary tick variant drives the timer-match bit. The system and hypervisor variants drive the system-timer-match bit. All variants are meant to count at a nominal 100 MHz enable rate.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the count and compare value are zero and the disable flag is 1. A count read therefore returns 64'h8000_0000_0000_0000. No pulse is emitted.
- R2: A write with `wr_sel`=0 loads `wr_data[62:0]` into the count and loads `wr_data[63]` into the disable flag. The new value is readable on the following cycle.
- R3: The count increments by exactly one on each cycle with `tick_en`=1 and no count write. It wraps modulo 2^63 and holds when `tick_en`=0. Counting continues while the flag is set.
- R4: `rd_data[63]` always shows the disable flag. `rd_data[62:0]` shows the count when `rd_sel`=0 and the compare value when `rd_sel`=1.
- R5: A write with `wr_sel`=1 loads `wr_data[62:0]` as the compare value and `wr_data[63]` as the disable flag, and arms the compare. Consider the first later cycle that has `tick_en`=1, no write, and a count that is at least the compare value. The pulse is high in the cycle after that one.
- R6: A compare value of zero never arms and never produces a pulse.
- R7: Setting the disable flag cancels the compare, whether the flag is set by a compare write or by a count write. A later write that only clears the flag through the count register does not re-arm it. No pulse occurs while the flag is 1.
- R8: A compare value at or below the current count fires on the next enabled cycle and is not lost.
- R9: Each compare write produces at most one pulse. A further match needs a new compare write.
- R10: Each pulse lasts exactly one cycle and is always accompanied by `wake`. With `VARIANT`=0 it appears on `soft_set_tm` only. With any other `VARIANT` it appears on `soft_set_stm` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one increment per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 compare |
| wr_data | input | CW | Write data; top bit is the disable flag |
| rd_sel | input | 1 | Read source: 0 count, 1 compare |
| rd_data | output | CW | Flag in top bit, selected value below |
| soft_set_tm | output | 1 | Timer-match soft bit set pulse (VARIANT 0) |
| soft_set_stm | output | 1 | System-timer-match soft bit set pulse (other variants) |
| wake | output | 1 | Core wake pulse on every firing |

## Verification
The hardest case to reach is a compare that was armed and then cancelled. A count write that sets the flag leaves no trace in the compare value itself. A second count write that clears the flag makes the timer look fully enabled again. The bench builds this case with four back-to-back writes: count, compare, count with the flag set, and count with the flag clear. It then runs well past the compare value and requires silence. It also puts the count beyond the compare value before writing the compare, to show that such a compare fires after one tick and only once.

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
  parameter int CW      = 64,
  parameter int VARIANT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [CW-1:0] rd_data,
  output logic          soft_set_tm,
  output logic          soft_set_stm,
  output logic          wake
);
  localparam int VW = CW - 1;

  logic [VW-1:0] cnt_q, lim_q;
  logic          dis_q, armed_q, fire_q;

  wire [VW-1:0] wr_val  = wr_data[VW-1:0];
  wire          wr_flag = wr_data[CW-1];
  wire          cnt_wr  = wr_en && !wr_sel;
  wire          lim_wr  = wr_en && wr_sel;
  wire          hit     = armed_q && !dis_q && tick_en && !wr_en && (cnt_q >= lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lim_q   <= '0;
      dis_q   <= 1'b1;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= hit;
      if (cnt_wr) begin
        cnt_q <= wr_val;
        dis_q <= wr_flag;
        if (wr_flag) armed_q <= 1'b0;
      end else if (tick_en) begin
        cnt_q <= cnt_q + {{(VW-1){1'b0}}, 1'b1};
      end
      if (lim_wr) begin
        lim_q   <= wr_val;
        dis_q   <= wr_flag;
        armed_q <= (wr_val != '0) && !wr_flag;
      end else if (hit) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign rd_data = {dis_q, rd_sel ? lim_q : cnt_q};
  assign wake    = fire_q;

  generate
    if (VARIANT == 0) begin : g_tick
      assign soft_set_tm  = fire_q;
      assign soft_set_stm = 1'b0;
    end else begin : g_stick
      assign soft_set_tm  = 1'b0;
      assign soft_set_stm = fire_q;
    end
  endgenerate
endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk #(
  parameter int CW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          wr_en,
  input logic          wr_sel,
  input logic [CW-1:0] wr_data,
  input logic          soft_set_tm,
  input logic          soft_set_stm,
  input logic          wake,
  input logic [CW-2:0] cnt_q,
  input logic          dis_q
);
  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  // R10
  variant_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((soft_set_tm || soft_set_stm) == wake) && !(soft_set_tm && soft_set_stm));

  // R7
  disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !dis_q);

  // R2
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (cnt_q == $past(wr_data[CW-2:0])) && (dis_q == $past(wr_data[CW-1])));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tick_en) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tick_en) |=> $stable(cnt_q));

  // R6
  zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && (wr_data[CW-2:0] == '0)) |=> !wake);
endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .soft_set_tm(soft_set_tm), .soft_set_stm(soft_set_stm),
  .wake(wake), .cnt_q(cnt_q), .dis_q(dis_q)
);

// File: tb/tick_cmp_timer_tb.sv
module tick_cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd0, rd1;
  logic        tm0, stm0, wk0, tm1, stm1, wk1;
  int          n_vec = 0, n_bad = 0;
  int          p_tm0 = 0, p_stm0 = 0, p_wk0 = 0, p_tm1 = 0, p_stm1 = 0, p_wk1 = 0;

  always #4 clk = ~clk;

  tick_cmp_timer #(.CW(64), .VARIANT(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd0),
    .soft_set_tm(tm0), .soft_set_stm(stm0), .wake(wk0));

  tick_cmp_timer #(.CW(64), .VARIANT(1)) u_dut_s (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd1),
    .soft_set_tm(tm1), .soft_set_stm(stm1), .wake(wk1));

  always @(posedge clk) begin
    #1;
    if (tm0)  p_tm0++;
    if (stm0) p_stm0++;
    if (wk0)  p_wk0++;
    if (tm1)  p_tm1++;
    if (stm1) p_stm1++;
    if (wk1)  p_wk1++;
  end

  // {write data, read after write, read after three ticks}
  localparam logic [191:0] VEC [4] = '{
    {64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0008},
    {64'h8000_0000_0000_0010, 64'h8000_0000_0000_0010, 64'h8000_0000_0000_0013},
    {64'h7FFF_FFFF_FFFF_FFFE, 64'h7FFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0001},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0002}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; tick_en = 1'b0;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input logic en);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = en;
      @(posedge clk); #2;
    end
    tick_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [63:0] v);
    rd_sel = sel; #1; v = rd0;
  endtask

  task automatic clr;
    p_tm0 = 0; p_stm0 = 0; p_wk0 = 0; p_tm1 = 0; p_stm1 = 0; p_wk1 = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    run(2, 1'b0);

    // R1 reset state
    rd(1'b0, v); chk("R1 count read", v, 64'h8000_0000_0000_0000);
    rd(1'b1, v); chk("R1 limit read", v, 64'h8000_0000_0000_0000);
    chk("R1 no pulse", 64'(p_wk0 + p_wk1), 64'd0);

    // R2 R3 R4 vector table
    for (int k = 0; k < 4; k++) begin
      wr(1'b0, VEC[k][191:128]);
      rd(1'b0, v); chk("R2 count write", v, VEC[k][127:64]);
      run(3, 1'b1);
      rd(1'b0, v); chk("R3 count ticks", v, VEC[k][63:0]);
    end

    // R3 hold without enable
    wr(1'b0, 64'd7);
    run(4, 1'b0);
    rd(1'b0, v); chk("R3 hold", v, 64'd7);
    run(3, 1'b1);
    rd(1'b0, v); chk("R3 resume", v, 64'd10);

    // R5 exact firing, R4 limit read
    clr();
    wr(1'b0, 64'd10);
    wr(1'b1, 64'd15);
    rd(1'b1, v); chk("R4 limit read", v, 64'd15);
    run(5, 1'b1);
    rd(1'b0, v); chk("R5 count at limit", v, 64'd15);
    chk("R5 not yet", 64'(p_wk0), 64'd0);
    run(1, 1'b1);
    chk("R5 fired", 64'(p_wk0), 64'd1);
    // R10 routing by variant
    chk("R10 tm tick", 64'(p_tm0), 64'd1);
    chk("R10 stm tick", 64'(p_stm0), 64'd0);
    chk("R10 stm sys", 64'(p_stm1), 64'd1);
    chk("R10 tm sys", 64'(p_tm1), 64'd0);
    chk("R10 wake sys", 64'(p_wk1), 64'd1);
    // R9 once only
    run(10, 1'b1);
    chk("R9 single pulse", 64'(p_wk0), 64'd1);

    // R8 past limit fires on next tick
    clr();
    wr(1'b0, 64'd100);
    wr(1'b1, 64'd50);
    chk("R8 none before tick", 64'(p_wk0), 64'd0);
    run(1, 1'b1);
    chk("R8 next tick", 64'(p_wk0), 64'd1);
    run(6, 1'b1);
    chk("R9 past once", 64'(p_wk0), 64'd1);

    // R6 zero limit
    clr();
    wr(1'b0, 64'd0);
    wr(1'b1, 64'd0);
    run(10, 1'b1);
    chk("R6 zero limit", 64'(p_wk0 + p_wk1), 64'd0);

    // R7 disabled compare write
    clr();
    wr(1'b0, 64'd0);
    wr(1'b1, 64'h8000_0000_0000_0005);
    run(10, 1'b1);
    chk("R7 disabled limit", 64'(p_wk0 + p_wk1), 64'd0);
    rd(1'b0, v); chk("R7 flag on read", v, 64'h8000_0000_0000_000A);

    // R7 cancel via count write, no re-arm on clearing
    clr();
    wr(1'b0, 64'd0);
    wr(1'b1, 64'd5);
    wr(1'b0, 64'h8000_0000_0000_0000);
    wr(1'b0, 64'd0);
    run(12, 1'b1);
    chk("R7 cancelled", 64'(p_wk0 + p_wk1), 64'd0);

    // R1 reset again cancels an armed compare
    clr();
    wr(1'b0, 64'd0);
    wr(1'b1, 64'd3);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #2; rst_n = 1'b1;
    run(8, 1'b1);
    chk("R1 reset cancels", 64'(p_wk0), 64'd0);
    rd(1'b0, v); chk("R1 count restart", v, 64'h8000_0000_0000_0008);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule